// File: doc/BRIEF.md
# Variable-Length Successive-Approximation Sequencer

This block is the digital engine of a successive-approximation converter. A start command puts the sampling capacitor into hold, wipes the previous result, and runs a binary search. The search tests one bit of the code per decision, from the most significant bit downward. For each trial the external comparator reports whether the DAC code is above the sampled input. The trial bit is cleared when it is above, and kept otherwise. The DAC code output is the working result register, so the analog side always sees the code under test.

A length select, sampled with the start command, chooses between a full 12-decision search and a short 8-decision search. A short search stops with its next trial bit still set. The 12-bit word then reads back with bit 3 high and bits 2..0 low. When the search ends, busy drops, a one-cycle done pulse appears, and the sampler returns to tracking. A fixed acquisition window follows, and start is ignored during that window.

The controller has four named states:
- IDLE accepts start and moves to CONV.
- CONV makes one decision per divider period. It goes to DONE on the final decision and ignores start.
- DONE is a one-cycle pulse that moves to ACQ.
- ACQ counts the acquisition window and then returns to IDLE.

Top module: `sar_seq_top`

## Requirements
- R1: A start_i high seen in IDLE makes busy_o and hold_o high on the next cycle. At that point result_o equals 12'h800: the previous result is cleared and only the MSB trial is set.
- R2: One decision is made every DIV_CYC clock cycles, strictly from bit 11 downward. dac_code_o always equals result_o. After the first decision, bit 11 reflects the comparator and bit 10 is set as the new trial.
- R3: At a decision, a cmp_hi_i of 1 clears the trial bit and a cmp_hi_i of 0 keeps it. With an ideal comparator (cmp_hi_i = code > input), a 12-decision result equals the input code.
- R4: start_i is ignored during CONV, DONE and ACQ. A conversion in progress keeps its timing, its length and its result.
- R5: busy_o stays high for exactly 12*DIV_CYC cycles in long mode, or 8*DIV_CYC cycles in short mode. When busy_o falls, done_o is high for exactly one cycle.
- R6: short_i is sampled only with the start command; short_i = 1 selects 8 decisions. A short result has the input's top 8 bits in bits 11..4, bit 3 = 1, and bits 2..0 = 0.
- R7: hold_o rises only after a start command, and it is low from the done cycle onward, when the sampler is tracking.
- R8: After DONE, the block spends ACQ_CYC cycles in ACQ, with busy_o low and start ignored. After that, a start is accepted again.
- R9: After reset, busy_o, done_o and hold_o are low, result_o is zero, and the block is in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion command (level, sampled in IDLE) |
| short_i | input | 1 | 1 selects 8 decisions, 0 selects 12 |
| cmp_hi_i | input | 1 | Comparator: DAC code is above the held input |
| dac_code_o | output | RES_W | Code under test, driven to the DAC |
| result_o | output | RES_W | Successive-approximation register |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle end-of-conversion pulse |
| hold_o | output | 1 | Sampler in hold (1) or tracking (0) |

## Verification
The search is driven by a model comparator over inputs of several kinds:
- The extreme codes 0 and 4095 show whether every bit is kept or every bit is cleared.
- The codes 2047 and 2048 straddle the MSB decision and expose any error in bit order or in the keep/clear polarity.
- Random codes in both length modes are compared with an ideal floor quantizer. In short mode this isolates the tail pattern: bit 3 set, bits 2..0 clear.

Some conversions also receive a start with the opposite length in mid-search. Every conversion sees a start during DONE and another during ACQ. These checks separate a correctly latched length and ignored restarts from an engine that re-arms or changes its cycle count.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_DONE = 2'd2,
        ST_ACQ  = 2'd3
    } sar_state_e;

endpackage

// File: rtl/sar_clk_div.sv
// Decision-rate generator: one tick every DIV_CYC cycles while run_i is high.
module sar_clk_div #(
    parameter int DIV_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (DIV_CYC > 1) ? $clog2(DIV_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/sar_bit_reg.sv
// Approximation register with bit pointer and latched length.
module sar_bit_reg #(
    parameter int RES_W   = 12,
    parameter int SHORT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             short_i,
    input  logic             tick_i,
    input  logic             cmp_hi_i,
    output logic [RES_W-1:0] code_o,
    output logic             short_o,
    output logic             last_o
);
    localparam int PW = $clog2(RES_W + 1);
    localparam logic [PW-1:0] TOP_PTR   = PW'(RES_W - 1);
    localparam logic [PW-1:0] SHORT_END = PW'(RES_W - SHORT_W);
    localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

    logic [RES_W-1:0] sar_q;
    logic [RES_W-1:0] sar_nxt;
    logic [PW-1:0]    ptr_q;
    logic             short_q;
    logic [PW-1:0]    stop_ptr;

    assign stop_ptr = short_q ? SHORT_END : '0;

    // Per-bit update: the pointed bit takes the decision, the bit below it
    // becomes the next trial (even after the final short decision).
    genvar g;
    generate
        for (g = 0; g < RES_W; g++) begin : g_bit
            always_comb begin
                if (ptr_q == PW'(g)) begin
                    sar_nxt[g] = ~cmp_hi_i;
                end else if (ptr_q == PW'(g + 1)) begin
                    sar_nxt[g] = 1'b1;
                end else begin
                    sar_nxt[g] = sar_q[g];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sar_q   <= '0;
            ptr_q   <= TOP_PTR;
            short_q <= 1'b0;
        end else if (load_i) begin
            sar_q   <= MSB_ONLY;
            ptr_q   <= TOP_PTR;
            short_q <= short_i;
        end else if (tick_i) begin
            sar_q <= sar_nxt;
            if (ptr_q != stop_ptr) begin
                ptr_q <= ptr_q - 1'b1;
            end
        end
    end

    assign code_o  = sar_q;
    assign short_o = short_q;
    assign last_o  = tick_i && (ptr_q == stop_ptr);

endmodule

// File: rtl/sar_seq_ctrl.sv
// Sequencing state machine: IDLE -> CONV -> DONE -> ACQ -> IDLE.
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int ACQ_CYC = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       last_i,
    output sar_state_e state_o,
    output logic       load_o,
    output logic       run_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       hold_o
);
    localparam int AW = (ACQ_CYC > 1) ? $clog2(ACQ_CYC) : 1;
    localparam logic [AW-1:0] ACQ_LAST = AW'(ACQ_CYC - 1);

    sar_state_e    state_q, state_d;
    logic [AW-1:0] acq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            acq_q   <= '0;
        end else begin
            state_q <= state_d;
            acq_q   <= (state_q == ST_ACQ) ? acq_q + 1'b1 : '0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_CONV;
            ST_CONV: if (last_i)  state_d = ST_DONE;
            ST_DONE: state_d = ST_ACQ;
            ST_ACQ:  if (acq_q == ACQ_LAST) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_o = 1'b0;
        run_o  = 1'b0;
        busy_o = 1'b0;
        done_o = 1'b0;
        hold_o = 1'b0;
        unique case (state_q)
            ST_IDLE: load_o = start_i;
            ST_CONV: begin
                run_o  = 1'b1;
                busy_o = 1'b1;
                hold_o = 1'b1;
            end
            ST_DONE: done_o = 1'b1;
            ST_ACQ:  ;
            default: ;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
    import sar_seq_pkg::*;
#(
    parameter int RES_W   = 12,
    parameter int SHORT_W = 8,
    parameter int DIV_CYC = 4,
    parameter int ACQ_CYC = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             short_i,
    input  logic             cmp_hi_i,
    output logic [RES_W-1:0] dac_code_o,
    output logic [RES_W-1:0] result_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             hold_o
);
    sar_state_e       ctl_state;
    logic             load;
    logic             run;
    logic             tick;
    logic             last;
    logic             len_short;
    logic [RES_W-1:0] code;

    sar_seq_ctrl #(.ACQ_CYC(ACQ_CYC)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .last_i  (last),
        .state_o (ctl_state),
        .load_o  (load),
        .run_o   (run),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .hold_o  (hold_o)
    );

    sar_clk_div #(.DIV_CYC(DIV_CYC)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_o (tick)
    );

    sar_bit_reg #(.RES_W(RES_W), .SHORT_W(SHORT_W)) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .short_i  (short_i),
        .tick_i   (tick),
        .cmp_hi_i (cmp_hi_i),
        .code_o   (code),
        .short_o  (len_short),
        .last_o   (last)
    );

    assign dac_code_o = code;
    assign result_o   = code;

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk
    import sar_seq_pkg::*;
#(
    parameter int RES_W   = 12,
    parameter int SHORT_W = 8,
    parameter int DIV_CYC = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             hold_o,
    input logic [RES_W-1:0] result_o,
    input logic             len_short,
    input sar_state_e       ctl_state
);
    localparam int TAIL = RES_W - SHORT_W;
    localparam logic [TAIL-1:0] TAIL_PAT = {1'b1, {(TAIL-1){1'b0}}};
    localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};
    localparam int LIMIT = RES_W * DIV_CYC;

    int unsigned busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy_cnt <= 0;
        else        busy_cnt <= busy_o ? busy_cnt + 1 : 0;
    end

    p_start_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state == ST_IDLE && start_i) |=> (busy_o && hold_o && result_o == MSB_ONLY));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($countones(result_o ^ $past(result_o)) <= 2));

    p_no_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (busy_o || done_o));

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_fall_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    p_busy_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (busy_cnt < LIMIT));

    p_short_tail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && len_short) |-> (result_o[TAIL-1:0] == TAIL_PAT));

    p_hold_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_o) |-> $past(start_i));

    p_track_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !hold_o);

    p_acq_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state == ST_ACQ) |=> !busy_o);

endmodule

bind sar_seq_top sar_seq_chk #(
    .RES_W   (RES_W),
    .SHORT_W (SHORT_W),
    .DIV_CYC (DIV_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .hold_o    (hold_o),
    .result_o  (result_o),
    .len_short (len_short),
    .ctl_state (ctl_state)
);

// File: tb/sar_seq_top_tb.sv
module sar_seq_top_tb;
    localparam int W   = 12;
    localparam int SW  = 8;
    localparam int DIV = 4;
    localparam int ACQ = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          short_i = 1'b0;
    logic          cmp_hi_i;
    logic [W-1:0]  dac_code_o, result_o;
    logic          busy_o, done_o, hold_o;
    logic [W-1:0]  vin = '0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    assign cmp_hi_i = (dac_code_o > vin);

    sar_seq_top #(.RES_W(W), .SHORT_W(SW), .DIV_CYC(DIV), .ACQ_CYC(ACQ)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .short_i(short_i),
        .cmp_hi_i(cmp_hi_i), .dac_code_o(dac_code_o), .result_o(result_o),
        .busy_o(busy_o), .done_o(done_o), .hold_o(hold_o)
    );

    function automatic logic [W-1:0] exp_result(input logic [W-1:0] v, input bit sh);
        if (sh) return {v[W-1:W-SW], 1'b1, {(W-SW-1){1'b0}}};
        return v;
    endfunction

    function automatic logic [W-1:0] exp_first(input logic [W-1:0] v);
        return ((v >= 12'h800) ? 12'h800 : 12'h000) | 12'h400;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One conversion; returns at a negedge with the block back in IDLE.
    task automatic convert(input logic [W-1:0] v, input bit sh, input bit poke);
        int k;
        vin     = v;
        short_i = sh;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        k = 0;
        while (busy_o === 1'b1) begin
            k++;
            if (k == 1) begin
                check("R1 first code", result_o, 12'h800);
                check("R7 hold", {11'd0, hold_o}, 12'd1);
            end
            if (k == DIV + 1) begin
                check("R2 msb decision", result_o, exp_first(v));
                check("R2 dac equals result", dac_code_o, result_o);
            end
            if (poke && k == 3) begin start_i = 1'b1; short_i = ~sh; end
            if (poke && k == 4) begin start_i = 1'b0; short_i = sh; end
            if (k > 2 * W * DIV) break;
            @(negedge clk);
        end
        check("R5 busy length", 12'(k), 12'((sh ? SW : W) * DIV));
        check("R5 done pulse", {11'd0, done_o}, 12'd1);
        check(sh ? "R6 short result" : "R3 full result", result_o, exp_result(v, sh));
        check("R7 tracking at done", {11'd0, hold_o}, 12'd0);
        start_i = 1'b1;                       // start during DONE and ACQ
        @(negedge clk);
        check("R5 done one cycle", {11'd0, done_o}, 12'd0);
        check("R4 start in done ignored", {11'd0, busy_o}, 12'd0);
        @(negedge clk);
        start_i = 1'b0;
        check("R8 start in acq ignored", {11'd0, busy_o}, 12'd0);
        check("R4 result kept", result_o, exp_result(v, sh));
        repeat (ACQ - 1) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R9 reset busy/done/hold", {9'd0, busy_o, done_o, hold_o}, 12'd0);
        check("R9 reset result", result_o, 12'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 idle after reset", {11'd0, busy_o}, 12'd0);

        convert(12'd0,    1'b0, 1'b0);
        convert(12'd4095, 1'b0, 1'b0);
        convert(12'd2048, 1'b0, 1'b0);
        convert(12'd2047, 1'b0, 1'b0);
        convert(12'd0,    1'b1, 1'b0);
        convert(12'd4095, 1'b1, 1'b0);
        convert(12'd2047, 1'b1, 1'b1);
        convert(12'hA5C,  1'b0, 1'b1);
        for (int i = 0; i < 60; i++) begin
            convert(12'($urandom), 1'($urandom), (i % 5) == 0);
        end

        // R8: a start right after the acquisition window is accepted
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R8 start accepted after acq", {11'd0, busy_o}, 12'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule